// File: doc/BRIEF.md
# Programmable-Window GPIO Debounce Filter

This block cleans up a bank of general-purpose inputs before software or other logic reads them. Every raw pin first crosses into the system-clock domain through a two-stage synchronizer. A pin that is both set as an input and has its filter switched on is then debounced. The debounce sample rate comes from a slow-clock enable pulse, nominally 32.768 kHz, which a programmable 14-bit divider slows down further. Every other pin skips the filter and shows its synchronized level directly.

The divider value `div` sets a sample strobe once every `div + 1` slow ticks. The divided clock therefore has a full period of `2 * (div + 1)` slow ticks, and each pin is sampled twice per period. Every filtered pin has a two-state machine. In SETTLED, the output level matches the most recent sample. If a strobe finds a sample that differs from the output (transition *disagree*), the machine moves to PENDING. In PENDING, the next strobe either finds the same new level again (transition *confirm*: the output takes the new level and the machine returns to SETTLED) or finds the old level (transition *retract*: the machine returns to SETTLED and the output does not change). If a pin stops being filtered (transition *bypass*), the machine returns to SETTLED and the stored level follows the synchronized input.

A pulse that fits between two strobes can never be confirmed. A pulse that spans two strobe intervals is always confirmed. A pulse between those two lengths may or may not pass, depending on where it falls relative to the strobes. The read port returns the final pin levels ANDed with a caller mask.

Top module: `dbf_top`

## Requirements
- R1: While reset is held and just after it, the divider value is 0, and `rd_data` reads 0 when every input is low.
- R2: A pin whose filter bit is 0 shows its input on `rd_data` exactly two clock cycles later (two-stage synchronizer), with no further delay.
- R3: The sample strobe fires on the (div+1)-th slow tick after the previous strobe or after a divider write, for any div from 0 to 16383. A divider write takes priority over a tick in the same cycle.
- R4: On a filtered pin, a pulse shorter than div+1 slow ticks (half a divided period) never changes the output.
- R5: On a filtered pin, a pulse of 2*(div+1) slow ticks or longer (one divided period) always reaches the output, and the output returns to the resting level once the input has rested for the same span.
- R6: A filtered output changes only in the cycle after a sample strobe, and only when two consecutive strobes both see the new level. After an input edge, the output holds its old level for at least div+1 slow ticks plus one clock cycle.
- R7: `rd_data` equals the per-pin level ANDed with `rd_mask`. A bit whose mask bit is 0 reads as 0.
- R8: A divider write restarts the strobe count from zero. It does not change any filtered output in that cycle.
- R9: A pin is filtered only when `flt_en` is 1 and `dir_in` is 1 (input). A pin set as output with `flt_en` = 1 behaves as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable, one per slow-clock period |
| pins_in | input | W | Raw asynchronous pin levels |
| flt_en | input | W | Per-pin debounce enable |
| dir_in | input | W | Per-pin direction, 1 = input |
| div_wr | input | 1 | Load `div_val` into the divider and restart the count |
| div_val | input | DW | New divider value |
| rd_mask | input | W | Read mask |
| rd_data | output | W | Pin levels ANDed with `rd_mask` |

## Verification
The bench drives pulses at several phases against the free-running slow tick, with div at 0 and at 5. It checks that pulses one clock short of a strobe interval never appear at the output, which catches a filter that commits on a single sample. It also checks that pulses of two intervals always appear and then clear, which catches a divider running at the wrong rate or a filter that never commits. A divider write with a simultaneous input change must produce an output edge inside a four-cycle window: a divider that kept its old count would be late, and a filter that lost its level would glitch. Bypass pins, including an output-direction pin with its enable set, are compared every clock against a delayed copy of their inputs. A wrong synchronizer depth or a wrong enable decode shows up there at once.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    // Per-pin debounce state: settled on the output level, or one sample seen at a new level
    typedef enum logic {
        F_SETTLED = 1'b0,
        F_PENDING = 1'b1
    } flt_state_e;

    localparam int DBF_DIV_W_DEFAULT = 14;

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;

endmodule

// File: rtl/dbf_divider.sv
module dbf_divider #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] div_q,
    output logic          stb
);

    logic [DW-1:0] cnt_q;
    logic          at_limit;

    assign at_limit = (cnt_q == div_q);

    // Load wins over a tick; a tick that reaches the limit wraps the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= load_val;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    assign stb = tick && !load && at_limit;

endmodule

// File: rtl/dbf_pin_filter.sv
module dbf_pin_filter
    import dbf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic smp,
    input  logic din,
    output logic level
);

    flt_state_e state_q;
    flt_state_e state_d;
    logic       level_q;
    logic       differs;

    assign differs = (din != level_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_SETTLED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: disagree / confirm / retract / bypass
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_SETTLED: begin
                if (active && smp && differs) begin
                    state_d = F_PENDING;
                end
            end
            F_PENDING: begin
                if (!active || smp) begin
                    state_d = F_SETTLED;
                end
            end
            default: state_d = F_SETTLED;
        endcase
    end

    // Output level: track input when bypassed, commit on a second disagreeing sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else if (!active) begin
            level_q <= din;
        end else if ((state_q == F_PENDING) && smp && differs) begin
            level_q <= din;
        end
    end

    assign level = level_q;

endmodule

// File: rtl/dbf_top.sv
module dbf_top #(
    parameter int W  = 32,
    parameter int DW = dbf_pkg::DBF_DIV_W_DEFAULT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_tick,
    input  logic [W-1:0]  pins_in,
    input  logic [W-1:0]  flt_en,
    input  logic [W-1:0]  dir_in,
    input  logic          div_wr,
    input  logic [DW-1:0] div_val,
    input  logic [W-1:0]  rd_mask,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0]  pin_sync;
    logic [W-1:0]  pin_act;
    logic [W-1:0]  filt_lvl;
    logic [DW-1:0] div_q;
    logic          smp_stb;

    assign pin_act = flt_en & dir_in;

    dbf_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_in),
        .d_sync  (pin_sync)
    );

    dbf_divider #(.DW(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (slow_tick),
        .load     (div_wr),
        .load_val (div_val),
        .div_q    (div_q),
        .stb      (smp_stb)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        dbf_pin_filter u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (pin_act[i]),
            .smp    (smp_stb),
            .din    (pin_sync[i]),
            .level  (filt_lvl[i])
        );
    end

    assign rd_data = ((pin_act & filt_lvl) | (~pin_act & pin_sync)) & rd_mask;

endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
    parameter int W  = 32,
    parameter int DW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slow_tick,
    input logic [W-1:0]  pins_in,
    input logic          div_wr,
    input logic [DW-1:0] div_val,
    input logic [W-1:0]  rd_mask,
    input logic [W-1:0]  rd_data,
    input logic [W-1:0]  pin_act,
    input logic          smp_stb,
    input logic [DW-1:0] div_q,
    input logic [W-1:0]  filt_lvl
);

    logic [1:0]  live;
    logic [DW:0] tk_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else if (live != 2'd3) begin
            live <= live + 2'd1;
        end
    end

    // Independent count of ticks since the last strobe or divider write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tk_seen <= '0;
        end else if (div_wr) begin
            tk_seen <= '0;
        end else if (slow_tick) begin
            tk_seen <= smp_stb ? '0 : tk_seen + 1'b1;
        end
    end

    // R3: strobe spacing and write priority
    a_r3_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> (slow_tick && !div_wr && (tk_seen == {1'b0, div_q})));

    // R7: masked-out bits read zero
    a_r7_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~rd_mask) == '0));

    // R8: divider write loads the value
    a_r8_div_load: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (div_q == $past(div_val)));

    for (genvar i = 0; i < W; i++) begin : g_pin_chk
        // R2 / R9: bypass pins show the input from two cycles earlier
        a_r2_bypass_latency: assert property (@(posedge clk) disable iff (!rst_n)
            ((live >= 2'd2) && !pin_act[i]) |->
                (rd_data[i] == ($past(pins_in[i], 2) & rd_mask[i])));

        // R6: filtered level moves only after a strobe
        a_r6_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_act[i] && !smp_stb) |=> $stable(filt_lvl[i]));

        // R8: a divider write leaves filtered levels alone
        a_r8_keep_level: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_act[i] && div_wr) |=> $stable(filt_lvl[i]));
    end

endmodule

bind dbf_top dbf_checker #(.W(W), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .pins_in   (pins_in),
    .div_wr    (div_wr),
    .div_val   (div_val),
    .rd_mask   (rd_mask),
    .rd_data   (rd_data),
    .pin_act   (pin_act),
    .smp_stb   (smp_stb),
    .div_q     (div_q),
    .filt_lvl  (filt_lvl)
);

// File: tb/dbf_top_test.sv
module dbf_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int DW         = 14;
    localparam int TICK_EVERY = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slow_tick = 1'b0;
    logic [W-1:0]  pins_in;
    logic [W-1:0]  flt_en = '0;
    logic [W-1:0]  dir_in = '0;
    logic          div_wr = 1'b0;
    logic [DW-1:0] div_val = '0;
    logic [W-1:0]  rd_mask = '0;
    logic [W-1:0]  rd_data;

    logic          p0 = 1'b0;
    logic [W-1:0]  bg = '0;
    logic          bg_run = 1'b0;
    logic          cmp_on = 1'b0;
    int            tcnt = 0;
    int            checks = 0;
    int            fails = 0;
    logic [W-1:0]  h1 = '0;
    logic [W-1:0]  h2 = '0;

    assign pins_in = {bg[W-1:1], p0};

    dbf_top #(.W(W), .DW(DW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .pins_in   (pins_in),
        .flt_en    (flt_en),
        .dir_in    (dir_in),
        .div_wr    (div_wr),
        .div_val   (div_val),
        .rd_mask   (rd_mask),
        .rd_data   (rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        tcnt = (tcnt + 1) % TICK_EVERY;
        slow_tick = (tcnt == 0);
        if (bg_run) bg = {bg[W-2:0], bg[7] ^ bg[5] ^ bg[4] ^ bg[3]};
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference for bypass pins: two-cycle delayed input, compared every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = '0;
            h2 = '0;
        end else begin
            h2 = h1;
            h1 = pins_in;
        end
        #(CLK_PERIOD / 4);
        if (cmp_on) begin
            logic [W-1:0] byp;
            byp = ~(flt_en & dir_in);
            check((rd_data & byp) == (h2 & byp & rd_mask), "R2/R9/R7",
                  "bypass pins", int'(rd_data & byp), int'(h2 & byp & rd_mask));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_div(input int d);
        @(negedge clk);
        div_val = DW'(d);
        div_wr  = 1'b1;
        @(negedge clk);
        div_wr  = 1'b0;
    endtask

    task automatic settle(input bit base, input int s);
        @(negedge clk);
        p0 = base;
        wait_clk(3 * s + 8);
    endtask

    task automatic pulse_run(input int len, input bit base, input int s,
                             output bit seen, output bit fin);
        seen = 1'b0;
        @(negedge clk);
        p0 = ~base;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (rd_data[0] != base) seen = 1'b1;
        end
        p0 = base;
        for (int i = 0; i < 3 * s + 8; i++) begin
            @(negedge clk);
            if (rd_data[0] != base) seen = 1'b1;
        end
        fin = rd_data[0];
    endtask

    task automatic reject_set(input int len, input bit base, input int s,
                              input int tries, input string req);
        bit seen, fin;
        for (int k = 0; k < tries; k++) begin
            settle(base, s);
            wait_clk(k * 3);
            pulse_run(len, base, s, seen, fin);
            check(!seen, req, "short pulse leaked", int'(seen), 0);
        end
    endtask

    task automatic accept_set(input int len, input bit base, input int s,
                              input int tries, input string req);
        bit seen, fin;
        for (int k = 0; k < tries; k++) begin
            settle(base, s);
            wait_clk(k * 5);
            pulse_run(len, base, s, seen, fin);
            check(seen, req, "long pulse lost", int'(seen), 1);
            check(fin == base, req, "level after pulse", int'(fin), int'(base));
        end
    endtask

    initial begin
        bit seen, fin;
        int n;
        flt_en  = 8'h03;
        dir_in  = 8'hFD;
        rd_mask = 8'hFF;
        wait_clk(4);
        check(rd_data == '0, "R1", "rd_data in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        wait_clk(3);
        check(rd_data == '0, "R1", "rd_data after reset", int'(rd_data), 0);
        cmp_on = 1'b1;
        bg = 8'hA5;
        bg_run = 1'b1;

        // div = 0 from reset: strobe interval 4 clocks
        reject_set(3, 1'b0, 4, 4, "R4");
        reject_set(3, 1'b1, 4, 4, "R4");
        accept_set(8, 1'b0, 4, 4, "R5");
        accept_set(8, 1'b1, 4, 4, "R5");
        settle(1'b0, 4);
        pulse_run(6, 1'b0, 4, seen, fin);
        check(fin == 1'b0, "R4", "in-between pulse left residue", int'(fin), 0);

        // div = 5: strobe interval 24 clocks
        set_div(5);
        reject_set(23, 1'b0, 24, 2, "R3_R4");
        accept_set(48, 1'b0, 24, 2, "R3_R5");

        // R6: output holds for one interval plus one clock after an input edge
        settle(1'b0, 24);
        @(negedge clk);
        p0 = 1'b1;
        wait_clk(25);
        check(rd_data[0] == 1'b0, "R6", "early output edge", int'(rd_data[0]), 0);
        wait_clk(60);
        check(rd_data[0] == 1'b1, "R6", "output after hold", int'(rd_data[0]), 1);

        // R8: write div=2 together with a falling input; count restarts
        @(negedge clk);
        p0 = 1'b0;
        div_val = DW'(2);
        div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        check(rd_data[0] == 1'b1, "R8", "level kept across write", int'(rd_data[0]), 1);
        n = 1;
        while (rd_data[0] != 1'b0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(n >= 22 && n <= 25, "R8_R3", "clocks to edge after write", n, 22);

        // R7: masked read
        rd_mask = 8'h0F;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check((rd_data & 8'hF0) == '0, "R7", "masked bits", int'(rd_data), 0);
        end
        rd_mask = 8'hFF;
        wait_clk(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule